// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a free-running time-of-day value for precision time protocol timestamping. The value is a 64-bit whole-nanosecond count extended below the binary point by a 32-bit fraction. On each core clock edge while counting is on, the block adds a programmable 32.32 fixed-point step to the value. The upper 32 bits of the step are whole nanoseconds per cycle and the lower 32 bits are the fraction. A fraction that overflows carries into the nanosecond count in the same cycle, so clocks whose period is not a whole number of nanoseconds keep exact long-term time.

Software uses a small register port with an address, write data, write strobe, read strobe and read data. Through it, software switches counting on and off, reads the time, steps the time by loading it directly, and trims the frequency by rewriting the step while the counter runs. The reset value of the step is the nominal period for the clock frequency given as a parameter: (10^9 * 2^32) / CLK_HZ. For 800 MHz that is 1.25 ns, or 0x0000_0001_4000_0000.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the nanosecond count, the fraction and the control register read zero, and the step register reads the nominal step (0x0000_0001_4000_0000 at the default 800 MHz).
- R2: While the enable bit is 1 and no time register is written, each clock edge adds the step to the 96-bit value {nanoseconds, fraction}, and a fraction carry raises the nanosecond count in the same edge.
- R3: While the enable bit is 0 and no time register is written, the nanosecond count and the fraction hold their values.
- R4: A write to the integer time register (offset 0xF10) loads the 64-bit nanosecond count from the write data and clears the fraction at that clock edge, in place of that edge's increment.
- R5: A write to the fraction register (offset 0xF08) loads the fraction from write data bits [31:0] at that clock edge, leaves the nanosecond count unchanged and replaces that edge's increment.
- R6: A write to the step register (offset 0xF18) stores the 64-bit write data. The next edge's increment uses the new step and counting does not pause.
- R7: The control register (offset 0xF00) stores only write data bit 0 as the enable bit. A read returns the enable bit in bit 0 and zero in all other bits.
- R8: With the read strobe high, read data is the addressed register, combinationally in the same cycle: 0xF00 control, 0xF08 fraction (zero-extended), 0xF10 nanosecond count, 0xF18 step. Any other address reads zero, and read data is zero whenever the read strobe is low.
- R9: The nanosecond count wraps modulo 2^64.
- R10: A write to an address that is not one of the four offsets changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one increment per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (12) | Register offset |
| wdata | input | DATA_W (64) | Write data |
| wr | input | 1 | Write strobe, one register per cycle |
| rd | input | 1 | Read strobe |
| rdata | output | DATA_W (64) | Read data, combinational, zero when rd is low |

## Verification
The bound checker tests on every cycle that the value advances by exactly the held step while enabled, holds while disabled, and takes integer and fraction loads with priority over the increment. It also tests that step and enable writes land on the next edge and that read data is zero without a read strobe. Only the bench scenarios show the visible results of these rules: the reset value of the step, fraction carries observed through reads, 64-bit wraparound after a step near the top of the range, frequency changes while counting, and unmapped writes that leave every register intact.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
   // Register offsets decoded by the address port
   localparam int OFS_W = 12;
   localparam logic [OFS_W-1:0] OFS_CTRL = 12'hF00;
   localparam logic [OFS_W-1:0] OFS_FRAC = 12'hF08;
   localparam logic [OFS_W-1:0] OFS_INT  = 12'hF10;
   localparam logic [OFS_W-1:0] OFS_STEP = 12'hF18;

   typedef struct packed {
      logic ctrl;
      logic frac;
      logic intg;
      logic step;
   } reg_hit_t;
endpackage

// File: rtl/ptp_tod_decode.sv
module ptp_tod_decode
   import ptp_tod_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_hit_t          hit
);
   always_comb begin
      hit      = '0;
      hit.ctrl = (addr == ADDR_W'(OFS_CTRL));
      hit.frac = (addr == ADDR_W'(OFS_FRAC));
      hit.intg = (addr == ADDR_W'(OFS_INT));
      hit.step = (addr == ADDR_W'(OFS_STEP));
   end
endmodule

// File: rtl/ptp_tod_cfg.sv
module ptp_tod_cfg #(
   parameter int              DATA_W   = 64,
   parameter logic [63:0]     STEP_RST = 64'h0000_0001_4000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_step,
   input  logic [DATA_W-1:0] wdata,
   output logic              en_q,
   output logic [DATA_W-1:0] step_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         step_q <= DATA_W'(STEP_RST);
      end else begin
         if (wr_ctrl) en_q   <= wdata[0];
         if (wr_step) step_q <= wdata;
      end
   end
endmodule

// File: rtl/ptp_tod_accum.sv
module ptp_tod_accum #(
   parameter int INT_W      = 64,
   parameter int FRAC_W     = 32,
   parameter int STEP_INT_W = 32,
   parameter bit SPLIT_ADD  = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         en,
   input  logic [STEP_INT_W+FRAC_W-1:0] step,
   input  logic                         ld_int,
   input  logic                         ld_frac,
   input  logic [INT_W-1:0]             int_val,
   input  logic [FRAC_W-1:0]            frac_val,
   output logic [INT_W-1:0]             ns_q,
   output logic [FRAC_W-1:0]            frac_q
);
   localparam int ACC_W = INT_W + FRAC_W;

   logic [INT_W-1:0]  inc_ns;
   logic [FRAC_W-1:0] inc_frac;

   generate
      if (SPLIT_ADD) begin : g_split
         // Short fraction adder feeds its carry into the integer adder
         logic [FRAC_W:0] fsum;
         assign fsum     = {1'b0, frac_q} + {1'b0, step[FRAC_W-1:0]};
         assign inc_frac = fsum[FRAC_W-1:0];
         assign inc_ns   = ns_q + INT_W'(step[STEP_INT_W+FRAC_W-1:FRAC_W])
                                + INT_W'(fsum[FRAC_W]);
      end else begin : g_flat
         logic [ACC_W-1:0] sum;
         assign sum      = {ns_q, frac_q} + ACC_W'(step);
         assign inc_ns   = sum[ACC_W-1:FRAC_W];
         assign inc_frac = sum[FRAC_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ns_q   <= '0;
         frac_q <= '0;
      end else if (ld_int) begin
         ns_q   <= int_val;
         frac_q <= '0;
      end else if (ld_frac) begin
         frac_q <= frac_val;
      end else if (en) begin
         ns_q   <= inc_ns;
         frac_q <= inc_frac;
      end
   end
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
   import ptp_tod_pkg::*;
#(
   parameter longint unsigned CLK_HZ    = 64'd800_000_000,
   parameter int              ADDR_W    = 12,
   parameter int              DATA_W    = 64,
   parameter int              INT_W     = 64,
   parameter int              FRAC_W    = 32,
   parameter bit              SPLIT_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr,
   input  logic              rd,
   output logic [DATA_W-1:0] rdata
);
   localparam int STEP_INT_W = DATA_W - FRAC_W;
   localparam logic [127:0] STEP_WIDE =
      (128'd1_000_000_000 << FRAC_W) / 128'(CLK_HZ);
   localparam logic [63:0] STEP_NOM = STEP_WIDE[63:0];

   if (CLK_HZ == 0) begin : g_bad_hz
      $error("CLK_HZ must be nonzero");
   end
   if (ADDR_W < OFS_W) begin : g_bad_addr
      $error("ADDR_W too narrow for register offsets");
   end
   if (INT_W > DATA_W || FRAC_W >= DATA_W || STEP_INT_W > INT_W) begin : g_bad_w
      $error("inconsistent INT_W / FRAC_W / DATA_W");
   end
   if (DATA_W > 64) begin : g_bad_d
      $error("DATA_W above 64 not supported");
   end

   reg_hit_t          hit;
   logic              en_q;
   logic [DATA_W-1:0] step_q;
   logic [INT_W-1:0]  ns_q;
   logic [FRAC_W-1:0] frac_q;

   ptp_tod_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (addr),
      .hit  (hit)
   );

   ptp_tod_cfg #(.DATA_W(DATA_W), .STEP_RST(STEP_NOM)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr & hit.ctrl),
      .wr_step (wr & hit.step),
      .wdata   (wdata),
      .en_q    (en_q),
      .step_q  (step_q)
   );

   ptp_tod_accum #(
      .INT_W      (INT_W),
      .FRAC_W     (FRAC_W),
      .STEP_INT_W (STEP_INT_W),
      .SPLIT_ADD  (SPLIT_ADD)
   ) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_q),
      .step     (step_q),
      .ld_int   (wr & hit.intg),
      .ld_frac  (wr & hit.frac),
      .int_val  (wdata[INT_W-1:0]),
      .frac_val (wdata[FRAC_W-1:0]),
      .ns_q     (ns_q),
      .frac_q   (frac_q)
   );

   always_comb begin
      rdata = '0;
      if (rd) begin
         if (hit.ctrl)      rdata = DATA_W'(en_q);
         else if (hit.frac) rdata = DATA_W'(frac_q);
         else if (hit.intg) rdata = DATA_W'(ns_q);
         else if (hit.step) rdata = step_q;
      end
   end
endmodule

// File: rtl/ptp_tod_chk.sv
module ptp_tod_chk
   import ptp_tod_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 64,
   parameter int INT_W  = 64,
   parameter int FRAC_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              wr,
   input logic              rd,
   input logic [DATA_W-1:0] rdata,
   input logic              en_q,
   input logic [DATA_W-1:0] step_q,
   input logic [INT_W-1:0]  ns_q,
   input logic [FRAC_W-1:0] frac_q
);
   localparam int ACC_W = INT_W + FRAC_W;
   logic time_wr;
   assign time_wr = wr && (addr == ADDR_W'(OFS_INT) || addr == ADDR_W'(OFS_FRAC));

   p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && !time_wr) |=>
         ({ns_q, frac_q} == $past({ns_q, frac_q}) + ACC_W'($past(step_q))));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !time_wr) |=> ($stable(ns_q) && $stable(frac_q)));

   p_load_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == ADDR_W'(OFS_INT)) |=>
         (ns_q == $past(wdata[INT_W-1:0]) && frac_q == '0));

   p_load_frac_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == ADDR_W'(OFS_FRAC)) |=>
         (frac_q == $past(wdata[FRAC_W-1:0]) && $stable(ns_q)));

   p_step_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == ADDR_W'(OFS_STEP)) |=> (step_q == $past(wdata)));

   p_ctrl_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == ADDR_W'(OFS_CTRL)) |=> (en_q == $past(wdata[0])));

   p_ctrl_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr == ADDR_W'(OFS_CTRL)) |-> (rdata[DATA_W-1:1] == '0));

   p_idle_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |-> (rdata == '0));
endmodule

bind ptp_tod_counter ptp_tod_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .INT_W  (INT_W),
   .FRAC_W (FRAC_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .addr   (addr),
   .wdata  (wdata),
   .wr     (wr),
   .rd     (rd),
   .rdata  (rdata),
   .en_q   (en_q),
   .step_q (step_q),
   .ns_q   (ns_q),
   .frac_q (frac_q)
);

// File: tb/sim_ptp_tod_counter.sv
module sim_ptp_tod_counter;
   localparam int PERIOD = 10;
   localparam logic [11:0] A_CTRL = 12'hF00;
   localparam logic [11:0] A_FRAC = 12'hF08;
   localparam logic [11:0] A_INT  = 12'hF10;
   localparam logic [11:0] A_STEP = 12'hF18;
   localparam logic [11:0] A_NONE = 12'hF20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic [63:0] wdata = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [63:0] rdata;

   int total = 0;
   int fails = 0;
   logic [63:0] last_rd;

   // Reference state
   logic [63:0] m_ns;
   logic [31:0] m_frac;
   logic [63:0] m_step;
   logic        m_en;

   always #(PERIOD/2) clk = ~clk;

   ptp_tod_counter u0 (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (addr),
      .wdata (wdata),
      .wr    (wr),
      .rd    (rd),
      .rdata (rdata)
   );

   function automatic logic [63:0] model_read(input logic [11:0] a);
      case (a)
         A_CTRL:  return {63'd0, m_en};
         A_FRAC:  return {32'd0, m_frac};
         A_INT:   return m_ns;
         A_STEP:  return m_step;
         default: return 64'd0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One bus cycle: drive, compare read data, then advance the model at the edge
   task automatic cyc(input logic w, input logic r, input logic [11:0] a,
                      input logic [63:0] d, input string tag);
      logic [95:0] acc;
      @(negedge clk);
      wr = w; rd = r; addr = a; wdata = d;
      #1;
      last_rd = rdata;
      if (r) check(tag, rdata, model_read(a));
      else   check({tag, "/R8 idle"}, rdata, 64'd0);
      @(posedge clk);
      acc = {m_ns, m_frac} + {32'd0, m_step};
      if (w && a == A_INT) begin
         m_ns = d; m_frac = '0;
      end else if (w && a == A_FRAC) begin
         m_frac = d[31:0];
      end else if (m_en) begin
         m_ns = acc[95:32]; m_frac = acc[31:0];
      end
      if (w && a == A_CTRL) m_en = d[0];
      if (w && a == A_STEP) m_step = d;
   endtask

   initial begin
      #(PERIOD * 200000);
      fails++; total++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      m_ns = '0; m_frac = '0; m_en = 1'b0;
      m_step = (64'd1_000_000_000 << 32) / 64'd800_000_000;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      cyc(0, 1, A_CTRL, 0, "R1 ctrl");
      check("R1 ctrl literal", last_rd, 64'd0);
      cyc(0, 1, A_INT, 0, "R1 int");
      check("R1 int literal", last_rd, 64'd0);
      cyc(0, 1, A_FRAC, 0, "R1 frac");
      cyc(0, 1, A_STEP, 0, "R1 step");
      check("R1 step literal", last_rd, 64'h0000_0001_4000_0000);

      // R3: disabled counter holds
      for (int i = 0; i < 4; i++) cyc(0, 1, A_INT, 0, "R3 hold");

      // R2: enable and count at 1.25 ns per cycle
      cyc(1, 0, A_CTRL, 64'd1, "R7 enable");
      for (int i = 0; i < 12; i++) begin
         cyc(0, 1, A_INT, 0, "R2 int");
         cyc(0, 1, A_FRAC, 0, "R2 frac");
      end

      // R6: change the step while running
      cyc(1, 0, A_STEP, 64'h0000_0003_C000_0001, "R6 write");
      cyc(0, 1, A_STEP, 0, "R6 readback");
      for (int i = 0; i < 6; i++) begin
         cyc(0, 1, A_FRAC, 0, "R6 frac");
         cyc(0, 1, A_INT, 0, "R6 int");
      end

      // R4 then R9: load near the top and wrap
      cyc(1, 0, A_INT, 64'hFFFF_FFFF_FFFF_FFFD, "R4 load");
      cyc(0, 1, A_FRAC, 0, "R4 frac cleared");
      check("R4 frac literal", last_rd, 64'd0);
      for (int i = 0; i < 4; i++) cyc(0, 1, A_INT, 0, "R9 wrap");

      // R5: fraction load
      cyc(1, 0, A_FRAC, 64'hAAAA_AAAA_FFFF_FFFF, "R5 load");
      cyc(0, 1, A_FRAC, 0, "R5 frac");
      cyc(0, 1, A_INT, 0, "R5 int");

      // R7/R3: only bit 0 of control counts; disable holds time
      cyc(1, 0, A_CTRL, 64'hFFFF_FFFF_FFFF_FFFE, "R7 clear");
      cyc(0, 1, A_CTRL, 0, "R7 read0");
      for (int i = 0; i < 4; i++) cyc(0, 1, A_INT, 0, "R3 stopped");
      cyc(0, 1, A_FRAC, 0, "R3 stopped frac");
      cyc(1, 0, A_CTRL, 64'hFFFF_FFFF_FFFF_FFFF, "R7 set");
      cyc(0, 1, A_CTRL, 0, "R7 read1");
      check("R7 literal", last_rd, 64'd1);

      // R10: unmapped write changes nothing; R8: unmapped read is zero
      cyc(1, 0, A_NONE, 64'hFFFF_FFFF_FFFF_FFFF, "R10 write");
      cyc(0, 1, A_STEP, 0, "R10 step");
      cyc(0, 1, A_CTRL, 0, "R10 ctrl");
      cyc(0, 1, A_INT, 0, "R10 int");
      cyc(0, 1, A_FRAC, 0, "R10 frac");
      cyc(0, 1, A_NONE, 0, "R8 unmapped");
      check("R8 unmapped literal", last_rd, 64'd0);
      cyc(0, 1, 12'hF04, 0, "R8 gap");
      cyc(0, 0, A_INT, 0, "R8 no strobe");
      cyc(0, 1, A_INT, 0, "R2 final");

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule